// File: doc/BRIEF.md
# Write-Burst Read-Interrupt Sequencer

This block sits on the controller side of a double-data-rate SDRAM interface. It turns a stream of write and read requests into commands for the memory, and it drives the write data path. The burst length is fixed at 8 beats, and two beats cross the bus on every clock. A read that arrives while a write burst is still on the bus does not wait for the burst to finish. It cuts the burst short. The sequencer picks the earliest legal clock for the read and masks the write beats that must not reach the array. It also takes its drivers off the data bus and the strobe early enough for the memory to turn the bus around.

Requests use a valid/ready handshake. Each request carries:
- a read/write select,
- a bank,
- an address,
- an autoprecharge flag,
- a mark saying the read is meant to interrupt,
- for writes, the full 8-beat payload.

An accepted request appears on the command bus for one clock, in the clock after acceptance. While a request is waiting for its spacing slot, `req_ready` stays low.

The data path is a state machine with four states:
- **BUS_IDLE**: nothing is driven.
- **BUS_LEAD**: the clock that carries the write command, before any data.
- **BUS_DATA**: live beat pairs are driven.
- **BUS_TAIL**: the masked remainder of a burst that a read has cut.

Its transitions are:
- **start** (IDLE→LEAD): a write is accepted.
- **launch** (LEAD→DATA): the first beat pair goes out, with the pair counter at 0.
- **cut** (DATA→TAIL): a read is accepted before the last pair.
- **advance** (DATA→DATA, TAIL→TAIL): the pair counter increments.
- **drain** (DATA→IDLE, TAIL→IDLE): the last pair has gone out.
- **chain** (DATA→LEAD): the next write is accepted on the last pair.

Top module: `wr_intr_seq`

## Requirements
- R1: After reset, `cmd_op` is NOP (2'b00), `dm_out` is 2'b00, `dq_oe` and `dqs_en` are low, `ap_hold` is low, and `req_ready` is high for either kind of request.
- R2: A request accepted at a clock edge appears in the next clock as exactly one command: `cmd_op` is 2'b01 for write or 2'b10 for read. `cmd_bank`, `cmd_addr` and `cmd_ap` come from the request. Every other clock carries NOP.
- R3: Call T the clock in which a write command is on the bus. Clock T+1+k (k = 0..3) carries beat 2k on `dq_out[15:0]` and beat 2k+1 on `dq_out[31:16]`. Beat i is `req_wdata[16*i +: 16]`. `dq_oe` and `dqs_en` are high while a live pair is driven.
- R4: A read is never issued before T+2. A read that is valid during clock T sees `req_ready` low and is issued at T+2.
- R5: A read issued at clock R with T+2 ≤ R ≤ T+4 interrupts the write:
  - pairs in clocks before R-1 carry `dm_out` 2'b00;
  - the pair in clock R-1 carries `dm_out` 2'b10, with its upper beat driven as zero;
  - every pair from clock R on carries `dm_out` 2'b11, with zero data.
- R6: From the read clock R onward, `dq_oe` and `dqs_en` are low for the rest of the cut burst. This is at least one clock before read data, which appears CAS-latency (3) clocks after R.
- R7: A read issued at T+5 or later masks nothing, and all 8 beats go out unmasked.
- R8: After a write with `cmd_ap` set, no read is issued before T+5. `ap_hold` is high in each clock from T+1 to T+3 in which a valid read marked with `req_intr` is held back by that rule. It is low otherwise.
- R9: A read may target any bank. Its issue clock and the mask pattern do not depend on whether its bank matches the bank being written.
- R10: Command spacing:
  - a write follows a write by at least 5 clocks;
  - a read follows a read by at least 4 clocks;
  - a write follows a read by at least 7 clocks.

  A request held for spacing is issued exactly at the minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted this clock |
| req_read | input | 1 | 1 = read, 0 = write |
| req_intr | input | 1 | Read is meant to interrupt a running write |
| req_bank | input | 2 | Target bank |
| req_addr | input | 13 | Target address |
| req_ap | input | 1 | Autoprecharge with this command |
| req_wdata | input | 128 | Eight 16-bit write beats, beat 0 lowest |
| cmd_op | output | 2 | 00 NOP, 01 WRITE, 10 READ |
| cmd_bank | output | 2 | Bank of the issued command |
| cmd_addr | output | 13 | Address of the issued command |
| cmd_ap | output | 1 | Autoprecharge of the issued command |
| dq_out | output | 32 | Beat pair: even beat low, odd beat high |
| dm_out | output | 2 | Mask bits: bit0 even beat, bit1 odd beat |
| dqs_en | output | 1 | Strobe toggling enable |
| dq_oe | output | 1 | Data and strobe driver enable |
| ap_hold | output | 1 | Interrupting read held by autoprecharge rule |

## Verification
The bench sweeps the read request over every clock from 1 to 5 after the write request, with reads to the same bank and to a different bank. It then repeats the sweep with autoprecharge set, with the interrupt mark both on and off. For every clock it compares the command, the mask bits, the drive enables and the data against values computed from the write and read clocks.

Each corner case catches a specific error:
- **Request in the write clock itself:** a design that let this read through would issue it one clock after the write, which is illegal.
- **Pre-read beat:** a design that dropped the single-beat mask would write stale data into the array.
- **Late bus release:** if the drivers were still on when the memory turns the bus, the bench sees `dq_oe` high at the read clock.
- **Read at T+5:** this read must leave all beats unmasked, so a design that masked it would lose real data.
- **Autoprecharge write:** a read that cut such a burst would show up as an early READ command.

A separate pass holds a second command behind each of the four ordered pairs of command types, and checks that it is issued exactly at the spacing minimum.

// File: rtl/wis_pkg.sv
`timescale 1ns/1ps
package wis_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_READ  = 2'b10
    } cmd_e;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'b00,
        BUS_LEAD = 2'b01,
        BUS_DATA = 2'b10,
        BUS_TAIL = 2'b11
    } bus_e;

endpackage

// File: rtl/wis_spacing.sv
`timescale 1ns/1ps
module wis_spacing #(
    parameter int BURST_LEN = 8,
    parameter int CAS_LAT   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_read,
    input  logic req_intr,
    input  logic req_ap,
    input  logic wr_fire,
    input  logic rd_fire,
    output logic req_ready,
    output logic ap_hold,
    output logic wr_ap_q
);
    localparam int PAIRS   = BURST_LEN / 2;
    localparam int GAP_WTR = 2;
    localparam int GAP_WW  = PAIRS + 1;
    localparam int GAP_RR  = PAIRS;
    localparam int GAP_RW  = CAS_LAT + PAIRS;
    localparam int GAP_APR = PAIRS + 1;
    localparam int CNT_MAX = (GAP_RW > GAP_WW) ? GAP_RW : GAP_WW;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] SAT    = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] TH_WTR = CNT_W'(GAP_WTR - 1);
    localparam logic [CNT_W-1:0] TH_WW  = CNT_W'(GAP_WW - 1);
    localparam logic [CNT_W-1:0] TH_RR  = CNT_W'(GAP_RR - 1);
    localparam logic [CNT_W-1:0] TH_RW  = CNT_W'(GAP_RW - 1);
    localparam logic [CNT_W-1:0] TH_APR = CNT_W'(GAP_APR - 1);

    logic [CNT_W-1:0] since_wr;
    logic [CNT_W-1:0] since_rd;
    logic             wr_ok;
    logic             rd_ok;
    logic             wtr_met;
    logic             ap_block;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_wr <= SAT;
            since_rd <= SAT;
            wr_ap_q  <= 1'b0;
        end else begin
            if (wr_fire) begin
                since_wr <= '0;
                wr_ap_q  <= req_ap;
            end else if (since_wr != SAT) begin
                since_wr <= since_wr + CNT_W'(1);
            end
            if (rd_fire) begin
                since_rd <= '0;
            end else if (since_rd != SAT) begin
                since_rd <= since_rd + CNT_W'(1);
            end
        end
    end

    always_comb begin
        wtr_met  = (since_wr >= TH_WTR);
        ap_block = wr_ap_q && (since_wr < TH_APR);
        wr_ok    = (since_wr >= TH_WW) && (since_rd >= TH_RW);
        rd_ok    = (since_rd >= TH_RR) && wtr_met && !ap_block;
        req_ready = req_read ? rd_ok : wr_ok;
        ap_hold  = req_valid && req_read && req_intr && wtr_met && ap_block
                   && (since_rd >= TH_RR);
    end

    // R4: a read is never accepted in the clock that carries the write command
    p_no_read_at_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_wr == '0) |-> !rd_fire);

    // R8: the hold flag only rises while a read is actually being refused
    p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ap_hold |-> !rd_fire);

endmodule

// File: rtl/wis_cmd_reg.sv
`timescale 1ns/1ps
module wis_cmd_reg
    import wis_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              req_read,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_ap,
    output cmd_e              cmd_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              ap_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            addr_q <= '0;
            ap_q   <= 1'b0;
        end else if (fire) begin
            cmd_q  <= req_read ? CMD_READ : CMD_WRITE;
            bank_q <= req_bank;
            addr_q <= req_addr;
            ap_q   <= req_ap;
        end else begin
            cmd_q  <= CMD_NOP;
        end
    end

    // R2: any issued command is followed by a NOP clock
    p_one_clock_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));

endmodule

// File: rtl/wis_burst_fsm.sv
`timescale 1ns/1ps
module wis_burst_fsm
    import wis_pkg::*;
#(
    parameter int BURST_LEN = 8,
    parameter int DQ_W      = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_fire,
    input  logic                      rd_fire,
    input  logic [BURST_LEN*DQ_W-1:0] wdata_in,
    output logic [2*DQ_W-1:0]         dq_out,
    output logic [1:0]                dm_out,
    output logic                      dqs_en,
    output logic                      dq_oe
);
    localparam int PAIRS  = BURST_LEN / 2;
    localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam logic [PAIR_W-1:0] LAST = PAIR_W'(PAIRS - 1);

    bus_e                      state_q, state_d;
    logic [PAIR_W-1:0]         pair_q, pair_d;
    logic [BURST_LEN*DQ_W-1:0] wdata_q;
    logic [DQ_W-1:0]           beats [BURST_LEN];
    logic [DQ_W-1:0]           beat_lo, beat_hi;
    logic                      last_pair;
    logic                      cut_now;

    for (genvar i = 0; i < BURST_LEN; i++) begin : g_beat
        assign beats[i] = wdata_q[i*DQ_W +: DQ_W];
    end

    assign beat_lo   = beats[{pair_q, 1'b0}];
    assign beat_hi   = beats[{pair_q, 1'b1}];
    assign last_pair = (pair_q == LAST);
    assign cut_now   = rd_fire && !last_pair;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            pair_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            pair_q  <= pair_d;
            if (wr_fire) begin
                wdata_q <= wdata_in;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        pair_d  = pair_q;
        unique case (state_q)
            BUS_IDLE: begin
                pair_d = '0;
                if (wr_fire) state_d = BUS_LEAD;
            end
            BUS_LEAD: begin
                state_d = BUS_DATA;
                pair_d  = '0;
            end
            BUS_DATA: begin
                if (last_pair) begin
                    state_d = wr_fire ? BUS_LEAD : BUS_IDLE;
                    pair_d  = '0;
                end else begin
                    state_d = cut_now ? BUS_TAIL : BUS_DATA;
                    pair_d  = pair_q + PAIR_W'(1);
                end
            end
            BUS_TAIL: begin
                if (last_pair) begin
                    state_d = BUS_IDLE;
                    pair_d  = '0;
                end else begin
                    pair_d  = pair_q + PAIR_W'(1);
                end
            end
            default: begin
                state_d = BUS_IDLE;
                pair_d  = '0;
            end
        endcase
    end

    always_comb begin
        dq_out = '0;
        dm_out = 2'b00;
        dqs_en = 1'b0;
        dq_oe  = 1'b0;
        unique case (state_q)
            BUS_IDLE, BUS_LEAD: begin
                dm_out = 2'b00;
            end
            BUS_DATA: begin
                dq_oe  = 1'b1;
                dqs_en = 1'b1;
                dm_out = {cut_now, 1'b0};
                dq_out = {(cut_now ? {DQ_W{1'b0}} : beat_hi), beat_lo};
            end
            BUS_TAIL: begin
                dm_out = 2'b11;
            end
            default: begin
                dm_out = 2'b00;
            end
        endcase
    end

    // R3: the clock after a write command always drives a live pair
    p_lead_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_LEAD) |=> dq_oe);

    // R5: a masked tail only follows a clock whose odd beat was masked
    p_tail_after_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_TAIL) |-> $past(dm_out[1]));

    // R3: each burst carries exactly the pair count before leaving the data states
    p_pairs_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == BUS_DATA || state_q == BUS_TAIL) && !last_pair)
        |=> (state_q == BUS_DATA || state_q == BUS_TAIL));

endmodule

// File: rtl/wr_intr_seq.sv
`timescale 1ns/1ps
module wr_intr_seq
    import wis_pkg::*;
#(
    parameter int BURST_LEN = 8,
    parameter int CAS_LAT   = 3,
    parameter int DQ_W      = 16,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 13
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_read,
    input  logic                      req_intr,
    input  logic [BANK_W-1:0]         req_bank,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_ap,
    input  logic [BURST_LEN*DQ_W-1:0] req_wdata,
    output logic [1:0]                cmd_op,
    output logic [BANK_W-1:0]         cmd_bank,
    output logic [ADDR_W-1:0]         cmd_addr,
    output logic                      cmd_ap,
    output logic [2*DQ_W-1:0]         dq_out,
    output logic [1:0]                dm_out,
    output logic                      dqs_en,
    output logic                      dq_oe,
    output logic                      ap_hold
);
    logic fire;
    logic wr_fire;
    logic rd_fire;
    logic wr_ap_q;
    cmd_e cmd_q;

    assign fire    = req_valid && req_ready;
    assign wr_fire = fire && !req_read;
    assign rd_fire = fire && req_read;
    assign cmd_op  = cmd_q;

    wis_spacing #(
        .BURST_LEN (BURST_LEN),
        .CAS_LAT   (CAS_LAT)
    ) u_spacing (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_read  (req_read),
        .req_intr  (req_intr),
        .req_ap    (req_ap),
        .wr_fire   (wr_fire),
        .rd_fire   (rd_fire),
        .req_ready (req_ready),
        .ap_hold   (ap_hold),
        .wr_ap_q   (wr_ap_q)
    );

    wis_cmd_reg #(
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .req_read (req_read),
        .req_bank (req_bank),
        .req_addr (req_addr),
        .req_ap   (req_ap),
        .cmd_q    (cmd_q),
        .bank_q   (cmd_bank),
        .addr_q   (cmd_addr),
        .ap_q     (cmd_ap)
    );

    wis_burst_fsm #(
        .BURST_LEN (BURST_LEN),
        .DQ_W      (DQ_W)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_fire),
        .rd_fire  (rd_fire),
        .wdata_in (req_wdata),
        .dq_out   (dq_out),
        .dm_out   (dm_out),
        .dqs_en   (dqs_en),
        .dq_oe    (dq_oe)
    );

    // R4: no read in the clock right after a write command
    p_wtr_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_READ) |-> ($past(cmd_q) != CMD_WRITE));

    // R6: drivers are off in the clock the read command is issued
    p_bus_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_READ) |-> (!dq_oe && !dqs_en));

    // R8: a burst written with autoprecharge is never masked by a read
    p_ap_uncut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_out == 2'b11) |-> !wr_ap_q);

    // R2: an accepted read shows up as a READ command in the next clock
    p_read_issued_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> (cmd_q == CMD_READ));

endmodule

// File: tb/tb_wr_intr_seq.sv
`timescale 1ns/1ps
module tb_wr_intr_seq;
    localparam int BL   = 8;
    localparam int DQW  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_read = 1'b0;
    logic            req_intr = 1'b0;
    logic [1:0]      req_bank = '0;
    logic [12:0]     req_addr = '0;
    logic            req_ap = 1'b0;
    logic [BL*DQW-1:0] req_wdata = '0;
    logic [1:0]      cmd_op;
    logic [1:0]      cmd_bank;
    logic [12:0]     cmd_addr;
    logic            cmd_ap;
    logic [2*DQW-1:0] dq_out;
    logic [1:0]      dm_out;
    logic            dqs_en;
    logic            dq_oe;
    logic            ap_hold;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    wr_intr_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_read(req_read), .req_intr(req_intr), .req_bank(req_bank),
        .req_addr(req_addr), .req_ap(req_ap), .req_wdata(req_wdata),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap),
        .dq_out(dq_out), .dm_out(dm_out), .dqs_en(dqs_en), .dq_oe(dq_oe),
        .ap_hold(ap_hold)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [DQW-1:0] beat_of(input int cid, input int i);
        return DQW'((cid + 1) * 256 + i * 17 + 3);
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Write requested in clock 0, read requested from clock k until accepted.
    task automatic run_case(input int cid, input int k, input bit ap,
                            input bit intr, input bit other_bank);
        int  f, rr, t;
        bit  rd_done;
        bit  interrupt;
        logic [1:0] exp_dm;
        logic [2*DQW-1:0] exp_dq;
        bit exp_oe;
        string tag;
        t  = 1;
        f  = (ap ? 5 : 2);
        if (k > f) f = k;
        rr = f + 1;
        interrupt = (rr <= t + 4);
        rd_done = 1'b0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (c == 0) begin
                req_valid = 1'b1; req_read = 1'b0; req_bank = 2'd1;
                req_addr = 13'(cid); req_ap = ap; req_intr = 1'b0;
                for (int i = 0; i < BL; i++) req_wdata[i*DQW +: DQW] = beat_of(cid, i);
            end else if (c >= k && !rd_done) begin
                req_valid = 1'b1; req_read = 1'b1; req_ap = 1'b0;
                req_bank = other_bank ? 2'd2 : 2'd1;
                req_addr = 13'(100 + cid); req_intr = intr;
            end else begin
                req_valid = 1'b0;
            end
            #1;
            // handshake
            if (req_valid && c == 0)
                chk(req_ready == 1'b1, "R2", "write ready", req_ready, 1);
            if (req_valid && req_read)
                chk(req_ready == (c == f), ap ? "R8" : "R4", "read ready", req_ready, (c == f));
            chk(ap_hold == (ap && intr && c >= k && c >= 2 && c <= 4), "R8", "ap_hold",
                ap_hold, (ap && intr && c >= k && c >= 2 && c <= 4));
            // command bus
            if (c == t) begin
                chk(cmd_op == 2'b01, "R2", "write cmd", cmd_op, 1);
                chk(cmd_ap == ap, "R8", "write ap", cmd_ap, ap);
                chk(cmd_addr == 13'(cid), "R2", "write addr", cmd_addr, cid);
            end else if (c == rr) begin
                chk(cmd_op == 2'b10, ap ? "R8" : "R4", "read cmd", cmd_op, 2);
                chk(cmd_bank == (other_bank ? 2'd2 : 2'd1), "R9", "read bank",
                    cmd_bank, (other_bank ? 2 : 1));
            end else begin
                chk(cmd_op == 2'b00, "R2", "nop", cmd_op, 0);
            end
            // data path
            exp_dm = 2'b00; exp_dq = '0; exp_oe = 1'b0;
            if (c >= t + 1 && c <= t + 4) begin
                if (interrupt && c >= rr) begin
                    exp_dm = 2'b11;
                end else if (interrupt && c == rr - 1) begin
                    exp_dm = 2'b10; exp_oe = 1'b1;
                    exp_dq = {{DQW{1'b0}}, beat_of(cid, 2*(c-t-1))};
                end else begin
                    exp_oe = 1'b1;
                    exp_dq = {beat_of(cid, 2*(c-t-1)+1), beat_of(cid, 2*(c-t-1))};
                end
            end
            tag = interrupt ? (other_bank ? "R9" : "R5") : "R7";
            chk(dm_out == exp_dm, tag, "dm", dm_out, exp_dm);
            chk(dq_out == exp_dq, interrupt ? "R5" : "R3", "dq", dq_out, exp_dq);
            chk(dq_oe == exp_oe, "R6", "dq_oe", dq_oe, exp_oe);
            chk(dqs_en == exp_oe, "R6", "dqs_en", dqs_en, exp_oe);
            if (req_valid && req_ready && req_read) rd_done = 1'b1;
        end
        idle(10);
    endtask

    // First command in clock 0, second held from clock 1; gap in clocks.
    task automatic two_cmd(input bit first_rd, input bit second_rd, input int gap);
        bit sent;
        sent = 1'b0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            req_ap = 1'b0; req_intr = 1'b0; req_bank = 2'd0; req_addr = 13'd7;
            if (c == 0) begin
                req_valid = 1'b1; req_read = first_rd;
            end else if (!sent) begin
                req_valid = 1'b1; req_read = second_rd;
            end else begin
                req_valid = 1'b0;
            end
            #1;
            if (c > 0 && !sent)
                chk(req_ready == (c == gap), "R10", "spacing ready", req_ready, (c == gap));
            if (c == 1)
                chk(cmd_op == (first_rd ? 2'b10 : 2'b01), "R10", "first cmd", cmd_op,
                    first_rd ? 2 : 1);
            else if (c == gap + 1)
                chk(cmd_op == (second_rd ? 2'b10 : 2'b01), second_rd && !first_rd ? "R4" : "R10",
                    "second cmd", cmd_op, second_rd ? 2 : 1);
            else
                chk(cmd_op == 2'b00, "R10", "gap nop", cmd_op, 0);
            if (c > 0 && req_valid && req_ready) sent = 1'b1;
        end
        idle(12);
    endtask

    initial begin
        int cid;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(cmd_op == 2'b00, "R1", "reset cmd", cmd_op, 0);
        chk(dm_out == 2'b00, "R1", "reset dm", dm_out, 0);
        chk(!dq_oe && !dqs_en, "R1", "reset oe", {dq_oe, dqs_en}, 0);
        chk(ap_hold == 1'b0, "R1", "reset ap_hold", ap_hold, 0);
        req_read = 1'b1; #0.5;
        chk(req_ready == 1'b1, "R1", "reset read ready", req_ready, 1);
        req_read = 1'b0; #0.5;
        chk(req_ready == 1'b1, "R1", "reset write ready", req_ready, 1);
        idle(2);
        cid = 0;
        for (int k = 1; k <= 5; k++) begin
            for (int ob = 0; ob < 2; ob++) begin
                run_case(cid, k, 1'b0, 1'b1, ob[0]);
                cid++;
            end
        end
        for (int k = 1; k <= 5; k += 2) begin
            for (int it = 0; it < 2; it++) begin
                run_case(cid, k, 1'b1, it[0], 1'b1);
                cid++;
            end
        end
        two_cmd(1'b0, 1'b0, 5);
        two_cmd(1'b1, 1'b1, 4);
        two_cmd(1'b1, 1'b0, 7);
        two_cmd(1'b0, 1'b1, 2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule